// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block resolves control flow for a simple 32-bit load/store processor. Each cycle in which an instruction is presented, it decides whether the instruction is a branch and whether that branch's condition holds against the negative (N) and zero (Z) flags. From that decision it produces the next word-addressed program counter. A taken branch reaches its target in one of two ways. It can add a signed 20-bit displacement to the incremented PC, or it can take a byte address from a register operand and shift that address down to a word index.

A taken branch may also ask for a return address to be written into the link register, which is register 15. That address is a byte address, while the PC counts in words. The block reports a halt whenever the next PC it computes is word zero. Instruction fetch, flag generation and the register file all sit outside the block. The surrounding pipeline supplies the register operand and the flags and consumes the registered results one cycle later.

Top module: `bru_unit`

## Requirements
- R1: An instruction whose bits 31:30 are not 2'b11 is not a branch: the next PC is the current PC plus one, there is no link write, and halt follows R8 only.
- R2: For a branch, the 4-bit condition in bits 27:24 is met as follows. Code 7 always holds. Code 0 holds when N is set and code 1 when Z is set. Codes 5 and 6 hold when N or Z is set. Code 9 holds when Z is clear and code 13 when N is clear. Code 14 holds when both N and Z are clear.
- R3: The condition codes 2, 3, 4, 8, 10, 11, 12 and 15 never hold.
- R4: A branch whose condition does not hold gives the current PC plus one as the next PC and requests no link write.
- R5: A taken branch with bit 29 set gives a next PC of the current PC plus one plus the sign-extended displacement in bits 19:0. The sum wraps at the PC width.
- R6: A taken branch with bit 29 clear gives a next PC equal to the register operand divided by four, that is operand bits PC_W+1:2.
- R7: A taken branch with bit 28 set requests a link write, and the link data is (current PC + 1) * 4. With bit 28 clear, or on a branch that is not taken, there is no link request.
- R8: Halt is asserted with a result exactly when the next PC of that result is zero.
- R9: Results appear one clock after an instruction is accepted on `instrValid`. `resValid` is high only in that cycle, and `linkWe` and `halt` are low whenever `resValid` is low.
- R10: After reset, `resValid`, `linkWe` and `halt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| pcWord | input | PC_W | Word address of the current instruction |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| regC | input | DATA_W | Register operand selected by bits 3:0 |
| resValid | output | 1 | Result registers hold a new result |
| nextPc | output | PC_W | Next word program counter |
| linkWe | output | 1 | Write linkData into register 15 |
| linkData | output | DATA_W | Return byte address |
| halt | output | 1 | Next PC is zero |

## Verification
The in-design assertions cover the timing and gating rules on every cycle. They check the one-cycle latency, that link and halt stay quiet when no result is present, and that a halt always carries a zero PC. They also check that an untaken branch steps the PC by one and that an unlisted condition code is never taken. The arithmetic of the targets can only be shown by the bench's scenarios, which compare each result against an independent model. These scenarios cover every condition code under all four flag combinations, negative and wrapping displacements, register targets with unaligned low bits, and halts reached by each route.

// File: rtl/bru_pkg.sv
package bru_pkg;

  // Condition codes that can be taken; every other code is never taken.
  typedef enum logic [3:0] {
    CC_NEG      = 4'd0,
    CC_ZERO     = 4'd1,
    CC_LOWSAME  = 4'd5,
    CC_LESSEQ   = 4'd6,
    CC_ALWAYS   = 4'd7,
    CC_NONZERO  = 4'd9,
    CC_NONNEG   = 4'd13,
    CC_POSITIVE = 4'd14
  } condCode_t;

  localparam logic [1:0] BRANCH_CLASS = 2'b11;
  localparam int unsigned OFF_W = 20;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // accept a new instruction this cycle
    logic taken;      // branch is taken
    logic relTarget;  // taken target is PC-relative
    logic doLink;     // request link register write
  } bruStrobe_t;

  function automatic logic condHolds(input logic [3:0] code, input logic n, input logic z);
    logic res;
    case (code)
      CC_NEG:      res = n;
      CC_ZERO:     res = z;
      CC_LOWSAME:  res = n | z;
      CC_LESSEQ:   res = n | z;
      CC_ALWAYS:   res = 1'b1;
      CC_NONZERO:  res = ~z;
      CC_NONNEG:   res = ~n;
      CC_POSITIVE: res = ~n & ~z;
      default:     res = 1'b0;
    endcase
    return res;
  endfunction

  function automatic logic codeListed(input logic [3:0] code);
    return code inside {4'd0, 4'd1, 4'd5, 4'd6, 4'd7, 4'd9, 4'd13, 4'd14};
  endfunction

endpackage

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrValid,
  input  logic [7:0] instrHigh,   // instruction bits 31:24
  input  logic       flagN,
  input  logic       flagZ,
  output bruStrobe_t strobe
);

  logic       isBranch;
  logic       useRel;
  logic       wantLink;
  logic [3:0] condField;
  logic       condMet;

  always_comb begin
    isBranch  = (instrHigh[7:6] == BRANCH_CLASS);
    useRel    = instrHigh[5];
    wantLink  = instrHigh[4];
    condField = instrHigh[3:0];
    condMet   = condHolds(condField, flagN, flagZ);
  end

  always_comb begin
    strobe.load      = instrValid;
    strobe.taken     = instrValid & isBranch & condMet;
    strobe.relTarget = useRel;
    strobe.doLink    = instrValid & isBranch & condMet & wantLink;
  end

  // R3: an unlisted code must never lead to a taken branch
  p_unlisted_never_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrHigh[7:6] == 2'b11 && !codeListed(instrHigh[3:0])) |-> !strobe.taken);

  // R1: non-branch instructions never take
  p_nonbranch_flat_r1: assert property (@(posedge clk) disable iff (!rstN)
    (instrHigh[7:6] != 2'b11) |-> (!strobe.taken && !strobe.doLink));

  // R2: the always code is taken whenever a branch is presented
  p_always_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrHigh == 8'hC7) |-> strobe.taken);

endmodule

// File: rtl/bru_datapath.sv
module bru_datapath
  import bru_pkg::*;
#(
  parameter int unsigned PC_W   = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bruStrobe_t        strobe,
  input  logic [OFF_W-1:0]  offField,
  input  logic [PC_W-1:0]   pcWord,
  input  logic [DATA_W-1:0] regC,
  output logic              resValid,
  output logic [PC_W-1:0]   nextPc,
  output logic              linkWe,
  output logic [DATA_W-1:0] linkData,
  output logic              halt
);

  logic [PC_W-1:0]   pcInc;
  logic [PC_W-1:0]   offExt;
  logic [PC_W-1:0]   relTarget;
  logic [PC_W-1:0]   regTarget;
  logic [PC_W-1:0]   nextD;
  logic [DATA_W-1:0] linkD;
  logic              unusedRegBits;

  // Displacement extension: width depends on the PC width
  generate
    if (PC_W > OFF_W) begin : g_ext_wide
      assign offExt = {{(PC_W - OFF_W){offField[OFF_W-1]}}, offField};
    end else if (PC_W == OFF_W) begin : g_ext_equal
      assign offExt = offField;
    end else begin : g_ext_narrow
      assign offExt = offField[PC_W-1:0];
    end
  endgenerate

  assign unusedRegBits = ^regC;

  always_comb begin
    pcInc     = pcWord + PC_W'(1);
    relTarget = pcInc + offExt;
    regTarget = PC_W'(regC >> 2);
    if (strobe.taken)
      nextD = strobe.relTarget ? relTarget : regTarget;
    else
      nextD = pcInc;
    linkD = DATA_W'({pcInc, 2'b00});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      nextPc   <= '0;
      linkWe   <= 1'b0;
      linkData <= '0;
      halt     <= 1'b0;
    end else begin
      resValid <= strobe.load;
      linkWe   <= strobe.load & strobe.doLink;
      halt     <= strobe.load & (nextD == '0);
      if (strobe.load) begin
        nextPc   <= nextD;
        linkData <= linkD;
      end
    end
  end

  // R9: one-cycle latency
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> resValid);

  // R9: quiet outputs with no result
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!linkWe && !halt));

  // R8: halt carries a zero PC
  p_halt_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    halt |-> (nextPc == '0));

  // R4: untaken step by one
  p_untaken_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.taken) |=> (nextPc == $past(pcWord) + PC_W'(1)));

  // R7: link only on a taken branch, word aligned
  p_link_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkData[1:0] == 2'b00));

  p_link_taken_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.taken) |=> !linkWe);

endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int unsigned PC_W   = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [31:0]       instr,
  input  logic [PC_W-1:0]   pcWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic [DATA_W-1:0] regC,
  output logic              resValid,
  output logic [PC_W-1:0]   nextPc,
  output logic              linkWe,
  output logic [DATA_W-1:0] linkData,
  output logic              halt
);

  bruStrobe_t strobe;
  logic       unusedMidBits;

  assign unusedMidBits = ^instr[23:20];

  bru_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrHigh  (instr[31:24]),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .strobe     (strobe)
  );

  bru_datapath #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .offField (instr[OFF_W-1:0]),
    .pcWord   (pcWord),
    .regC     (regC),
    .resValid (resValid),
    .nextPc   (nextPc),
    .linkWe   (linkWe),
    .linkData (linkData),
    .halt     (halt)
  );

endmodule

// File: tb/bru_unit_tb_top.sv
module bru_unit_tb_top;

  localparam int unsigned PC_W   = 24;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instrValid = 1'b0;
  logic [31:0]       instr = '0;
  logic [PC_W-1:0]   pcWord = '0;
  logic              flagN = 1'b0;
  logic              flagZ = 1'b0;
  logic [DATA_W-1:0] regC = '0;
  logic              resValid;
  logic [PC_W-1:0]   nextPc;
  logic              linkWe;
  logic [DATA_W-1:0] linkData;
  logic              halt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [PC_W-1:0]   pc;
    logic              lw;
    logic [DATA_W-1:0] ld;
    logic              hl;
    string             tag;
  } exp_t;

  exp_t sbQ[$];

  always #10 clk = ~clk;  // 50 MHz

  bru_unit #(.PC_W(PC_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .pcWord(pcWord), .flagN(flagN), .flagZ(flagZ), .regC(regC),
    .resValid(resValid), .nextPc(nextPc), .linkWe(linkWe),
    .linkData(linkData), .halt(halt)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent model of the requirements
  function automatic bit modelCond(input logic [3:0] c, input logic n, input logic z);
    case (c)
      4'd0: return n;              // R2
      4'd1: return z;
      4'd5, 4'd6: return n | z;
      4'd7: return 1'b1;
      4'd9: return !z;
      4'd13: return !n;
      4'd14: return !n && !z;
      default: return 1'b0;        // R3
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] ins, input logic [PC_W-1:0] pc,
                                 input logic n, input logic z, input logic [DATA_W-1:0] rc,
                                 input string tag);
    exp_t e;
    logic [PC_W-1:0] inc;
    logic [PC_W-1:0] off;
    bit tk;
    inc = pc + 1;
    off = PC_W'(signed'(ins[19:0]));
    tk  = (ins[31:30] == 2'b11) && modelCond(ins[27:24], n, z);
    e.tag = tag;
    e.lw  = 1'b0;
    e.ld  = '0;
    if (!tk) e.pc = inc;                    // R1, R4
    else if (ins[29]) e.pc = inc + off;     // R5
    else e.pc = rc[PC_W+1:2];               // R6
    if (tk && ins[28]) begin                // R7
      e.lw = 1'b1;
      e.ld = DATA_W'(inc) * 4;
    end
    e.hl = (e.pc == 0);                     // R8
    return e;
  endfunction

  function automatic logic [31:0] mkBr(input logic [3:0] c, input bit u, input bit v, input logic [19:0] low);
    return {2'b11, u, v, c, 4'h0, low};
  endfunction

  task automatic send(input logic [31:0] ins, input logic [PC_W-1:0] pc,
                      input logic n, input logic z, input logic [DATA_W-1:0] rc, input string tag);
    @(negedge clk);
    instr = ins; pcWord = pc; flagN = n; flagZ = z; regC = rc; instrValid = 1'b1;
    sbQ.push_back(model(ins, pc, n, z, rc, tag));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      instrValid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (resValid) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R9 result without request", 64'(resValid), 64'(0));
        end else begin
          exp_t e;
          e = sbQ.pop_front();
          check(nextPc == e.pc, {e.tag, " nextPc"}, 64'(nextPc), 64'(e.pc));
          check(linkWe == e.lw, {e.tag, " R7 linkWe"}, 64'(linkWe), 64'(e.lw));
          if (e.lw) check(linkData == e.ld, {e.tag, " R7 linkData"}, 64'(linkData), 64'(e.ld));
          check(halt == e.hl, {e.tag, " R8 halt"}, 64'(halt), 64'(e.hl));
        end
      end else begin
        check(!linkWe && !halt, "R9 quiet when idle", 64'({linkWe, halt}), 64'(0));
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!resValid && !linkWe && !halt, "R10 reset outputs", 64'({resValid, linkWe, halt}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(!resValid && !linkWe && !halt, "R10 after release", 64'({resValid, linkWe, halt}), 64'(0));

    // R1: non-branch classes
    send(32'h0123_4567, 24'h000100, 1'b1, 1'b1, 32'h0, "R1 class00");
    send(32'h4000_0010, 24'h000200, 1'b0, 1'b0, 32'h0, "R1 class01");
    send(32'h8700_0000, 24'h000300, 1'b0, 1'b1, 32'h0, "R1 class10");
    idle(2);

    // R2 R3 R4 R7: every code under every flag combination, relative + link
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 4; f++) begin
        send(mkBr(4'(c), 1'b1, 1'b1, 20'h00010), 24'h001000 + 24'(c * 8 + f),
             f[1], f[0], 32'h0, $sformatf("R2 R3 code%0d flags%0d", c, f));
      end
    end
    idle(1);

    // R5: negative displacement and PC wrap
    send(mkBr(4'd7, 1'b1, 1'b0, 20'hFFFF0), 24'h000050, 1'b0, 1'b0, 32'h0, "R5 backward");
    send(mkBr(4'd7, 1'b1, 1'b0, 20'h7FFFF), 24'hFFFFF0, 1'b0, 1'b0, 32'h0, "R5 wrap");
    // R7: taken with no link bit
    send(mkBr(4'd9, 1'b1, 1'b0, 20'h00004), 24'h000060, 1'b0, 1'b0, 32'h0, "R7 nolink");
    // R4: untaken with link bit requests nothing
    send(mkBr(4'd1, 1'b1, 1'b1, 20'h00004), 24'h000070, 1'b0, 1'b0, 32'h0, "R4 untaken link");
    idle(3);

    // R6: register targets, unaligned low bits dropped
    send(mkBr(4'd7, 1'b0, 1'b1, 20'h00003), 24'h000080, 1'b0, 1'b0, 32'h0000_1237, "R6 reg");
    send(mkBr(4'd13, 1'b0, 1'b0, 20'h00005), 24'h000090, 1'b0, 1'b1, 32'hFF00_0400, "R6 reg high");
    // R8: halts by each route
    send(mkBr(4'd7, 1'b0, 1'b1, 20'h0000F), 24'h0000A0, 1'b0, 1'b0, 32'h0000_0003, "R8 reg zero");
    send(mkBr(4'd7, 1'b1, 1'b0, 20'hFFFF5), 24'h00000A, 1'b0, 1'b0, 32'h0, "R8 rel zero");
    send(32'h0000_0000, 24'hFFFFFF, 1'b0, 1'b0, 32'h0, "R8 step wrap");
    send(mkBr(4'd3, 1'b0, 1'b0, 20'h0), 24'hFFFFFF, 1'b1, 1'b1, 32'h0, "R3 R8 untaken wrap");
    idle(4);

    check(sbQ.size() == 0, "R9 all results seen", 64'(sbQ.size()), 64'(0));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule